// File: doc/BRIEF.md
# Asynchronous SRAM Bus Timing Master

This block is a synchronous controller that sits between a simple request port and an external byte-wide asynchronous static RAM with an 11-bit address. It accepts one read or one write at a time. It drives the memory's active-low chip enable, output enable and write enable, the address, and the write data together with its drive-enable flag. It also samples the returned byte on reads.

Every interval the memory requires is a whole number of system clocks. These counts are computed at elaboration from nanosecond parameters and a clock-period parameter. Each count is the rounded-up quotient of the time by the period, and never less than one clock. To move to another speed grade or another system clock, only those parameters change.

Reads hold chip enable and output enable low for one access phase and sample the data on its last clock. A recovery phase then lets the memory release the bus. Writes use a write-enable-controlled pulse with output enable kept high throughout. A short hold phase follows, in which address and data stay put after write enable rises.

Top module: `sram_timing_master`

## Requirements
- R1: While reset is asserted, req_ready is 1, sram_ce_n, sram_oe_n and sram_we_n are 1, sram_dq_oe is 0 and rsp_valid is 0.
- R2: A request is taken only on a clock edge where req_valid and req_ready are both 1. req_ready is 0 from the next clock until the cycle has fully ended. Request inputs presented while req_ready is 0 have no effect on the memory pins.
- R3: A read holds sram_ce_n=0, sram_oe_n=0 and sram_we_n=1 for exactly RD_ACC clocks. RD_ACC is the largest of the clock counts for the cycle time, the address/chip-enable access time and the output-enable access time (18 clocks at the defaults).
- R4: The byte on sram_dq_in is sampled on the last clock of the read access phase. It appears on rsp_rdata with rsp_valid=1 in the clock that follows.
- R5: After a read, sram_ce_n and sram_oe_n are 1 and sram_dq_oe is 0 for RD_REC clocks, the larger of the bus-release and address-hold counts (7 clocks at the defaults). No new cycle starts before this phase ends.
- R6: A write holds sram_ce_n=0, sram_we_n=0 and sram_dq_oe=1 for exactly WR_ACC clocks, with sram_dq_out equal to the accepted write data. WR_ACC is the largest of the counts for cycle time, write pulse width and data setup (18 clocks at the defaults).
- R7: After write enable rises, sram_ce_n and sram_we_n stay 1 for WR_HOLD clocks, the larger of the data-hold and address-hold counts (2 at the defaults). During these clocks sram_dq_oe stays 1 with the same data.
- R8: sram_addr equals the accepted address from the clock after acceptance until the next acceptance, and does not change in between.
- R9: sram_oe_n is 1 in every clock where sram_we_n is 0.
- R10: rsp_valid is 1 for exactly one clock per read and never after a write.
- R11: A time converts to clocks as ceil(ns / period) with a minimum of one. With a 4 ns period, 0 ns gives 1, 5 ns gives 2 and 8 ns gives 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 11 | Byte address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | One-clock pulse, rsp_rdata holds read data |
| rsp_rdata | output | 8 | Read data |
| sram_addr | output | 11 | Memory address |
| sram_dq_out | output | 8 | Data driven to memory on writes |
| sram_dq_in | input | 8 | Data returned by memory |
| sram_dq_oe | output | 1 | 1 = controller drives the data bus |
| sram_ce_n | output | 1 | Memory chip enable, active low |
| sram_oe_n | output | 1 | Memory output enable, active low |
| sram_we_n | output | 1 | Memory write enable, active low |

## Verification
The bench's memory model returns a poison byte unless output enable has been low for the full access count. A capture one clock early therefore reads wrong data, and a shortened access window shows up too. Writes to the two end addresses followed by reads tell a correct address path from a truncated one. A read immediately followed by a write exercises the bus-release recovery, and a write followed by a read exercises the hold phase. During busy cycles, request fields are scrambled with req_valid held high, which tells real request gating from a controller that re-samples its inputs. A stream of mixed transactions drawn from a shift register then compares every pin against the reference model on every clock.

// File: rtl/sram_tm_pkg.sv
package sram_tm_pkg;

  typedef enum logic [2:0] {
    PH_IDLE    = 3'd0,
    PH_RD_ACC  = 3'd1,
    PH_RD_REC  = 3'd2,
    PH_WR_ACC  = 3'd3,
    PH_WR_HOLD = 3'd4
  } phase_t;

  // Rounded-up clock count for a time, never below one clock.
  function automatic int unsigned ns_to_clk(input int unsigned t_ns,
                                            input int unsigned period_ns);
    int unsigned n;
    n = (t_ns + period_ns - 1) / period_ns;
    if (n == 0) n = 1;
    return n;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    return max2(max2(a, b), c);
  endfunction

  function automatic int unsigned cnt_width(input int unsigned max_val);
    int unsigned w;
    w = 1;
    while ((1 << w) <= max_val) w++;
    return w;
  endfunction

endpackage

// File: rtl/sram_tm_seq.sv
module sram_tm_seq
  import sram_tm_pkg::*;
#(
  parameter int unsigned RD_ACC  = 18,
  parameter int unsigned RD_REC  = 7,
  parameter int unsigned WR_ACC  = 18,
  parameter int unsigned WR_HOLD = 2,
  parameter int unsigned CNT_W   = 5
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   accept,
  input  logic   req_write,
  output phase_t phase,
  output logic   phase_done,
  output logic   capture_en
);

  logic [CNT_W-1:0] cnt;

  assign phase_done = (phase != PH_IDLE) && (cnt == '0);
  assign capture_en = (phase == PH_RD_ACC) && phase_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      cnt   <= '0;
    end else begin
      case (phase)
        PH_IDLE: begin
          if (accept) begin
            if (req_write) begin
              phase <= PH_WR_ACC;
              cnt   <= CNT_W'(WR_ACC - 1);
            end else begin
              phase <= PH_RD_ACC;
              cnt   <= CNT_W'(RD_ACC - 1);
            end
          end
        end
        PH_RD_ACC: begin
          if (phase_done) begin
            phase <= PH_RD_REC;
            cnt   <= CNT_W'(RD_REC - 1);
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        PH_WR_ACC: begin
          if (phase_done) begin
            phase <= PH_WR_HOLD;
            cnt   <= CNT_W'(WR_HOLD - 1);
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        PH_RD_REC, PH_WR_HOLD: begin
          if (phase_done) begin
            phase <= PH_IDLE;
            cnt   <= '0;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: begin
          phase <= PH_IDLE;
          cnt   <= '0;
        end
      endcase
    end
  end

endmodule

// File: rtl/sram_tm_dpath.sv
module sram_tm_dpath #(
  parameter int unsigned ADDR_W = 11,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              capture_en,
  input  logic [DATA_W-1:0] sram_dq_in,
  output logic [ADDR_W-1:0] sram_addr,
  output logic [DATA_W-1:0] sram_dq_out,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sram_addr   <= '0;
      sram_dq_out <= '0;
    end else if (accept) begin
      sram_addr   <= req_addr;
      sram_dq_out <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= capture_en;
      if (capture_en) rsp_rdata <= sram_dq_in;
    end
  end

endmodule

// File: rtl/sram_timing_master.sv
module sram_timing_master
  import sram_tm_pkg::*;
#(
  parameter int unsigned ADDR_W       = 11,
  parameter int unsigned DATA_W       = 8,
  parameter int unsigned CLK_PERIOD_NS = 4,
  parameter int unsigned T_CYCLE_NS   = 70,
  parameter int unsigned T_ACC_NS     = 70,
  parameter int unsigned T_OE_ACC_NS  = 35,
  parameter int unsigned T_WP_NS      = 50,
  parameter int unsigned T_DS_NS      = 30,
  parameter int unsigned T_DH_NS      = 5,
  parameter int unsigned T_AH_NS      = 5,
  parameter int unsigned T_HZ_NS      = 25
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] sram_addr,
  output logic [DATA_W-1:0] sram_dq_out,
  input  logic [DATA_W-1:0] sram_dq_in,
  output logic              sram_dq_oe,
  output logic              sram_ce_n,
  output logic              sram_oe_n,
  output logic              sram_we_n
);

  localparam int unsigned RD_ACC_CLKS = max3(ns_to_clk(T_CYCLE_NS, CLK_PERIOD_NS),
                                             ns_to_clk(T_ACC_NS, CLK_PERIOD_NS),
                                             ns_to_clk(T_OE_ACC_NS, CLK_PERIOD_NS));
  localparam int unsigned RD_REC_CLKS = max2(ns_to_clk(T_HZ_NS, CLK_PERIOD_NS),
                                             ns_to_clk(T_AH_NS, CLK_PERIOD_NS));
  localparam int unsigned WR_ACC_CLKS = max3(ns_to_clk(T_CYCLE_NS, CLK_PERIOD_NS),
                                             ns_to_clk(T_WP_NS, CLK_PERIOD_NS),
                                             ns_to_clk(T_DS_NS, CLK_PERIOD_NS));
  localparam int unsigned WR_HOLD_CLKS = max2(ns_to_clk(T_DH_NS, CLK_PERIOD_NS),
                                              ns_to_clk(T_AH_NS, CLK_PERIOD_NS));
  localparam int unsigned CNT_W = cnt_width(max2(RD_ACC_CLKS, WR_ACC_CLKS));

  // Named internal events for the checker
  phase_t phase;
  logic   phase_done;
  logic   capture_en;
  logic   accept;

  assign req_ready = (phase == PH_IDLE);
  assign accept    = req_valid && req_ready;

  assign sram_ce_n  = !((phase == PH_RD_ACC) || (phase == PH_WR_ACC));
  assign sram_oe_n  = (phase != PH_RD_ACC);
  assign sram_we_n  = (phase != PH_WR_ACC);
  assign sram_dq_oe = (phase == PH_WR_ACC) || (phase == PH_WR_HOLD);

  sram_tm_seq #(
    .RD_ACC (RD_ACC_CLKS),
    .RD_REC (RD_REC_CLKS),
    .WR_ACC (WR_ACC_CLKS),
    .WR_HOLD(WR_HOLD_CLKS),
    .CNT_W  (CNT_W)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .req_write (req_write),
    .phase     (phase),
    .phase_done(phase_done),
    .capture_en(capture_en)
  );

  sram_tm_dpath #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_dpath (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept     (accept),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .capture_en (capture_en),
    .sram_dq_in (sram_dq_in),
    .sram_addr  (sram_addr),
    .sram_dq_out(sram_dq_out),
    .rsp_valid  (rsp_valid),
    .rsp_rdata  (rsp_rdata)
  );

endmodule

// File: rtl/sram_tm_checker.sv
module sram_tm_checker #(
  parameter int unsigned ADDR_W  = 11,
  parameter int unsigned RD_CLKS = 18,
  parameter int unsigned WR_CLKS = 18
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic [ADDR_W-1:0] sram_addr,
  input logic              sram_dq_oe,
  input logic              sram_ce_n,
  input logic              sram_oe_n,
  input logic              sram_we_n,
  input logic              capture_en
);

  int unsigned oe_lo_cnt;
  int unsigned we_lo_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_lo_cnt <= 0;
      we_lo_cnt <= 0;
    end else begin
      oe_lo_cnt <= sram_oe_n ? 0 : oe_lo_cnt + 1;
      we_lo_cnt <= sram_we_n ? 0 : we_lo_cnt + 1;
    end
  end

  always_comb begin
    if (!rst_n) begin
      p_reset_idle_r1: assert (req_ready && sram_ce_n && sram_oe_n && sram_we_n && !sram_dq_oe)
        else $error("reset state wrong");
    end
  end

  p_ready_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  p_read_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_oe_n) |-> (oe_lo_cnt == RD_CLKS));

  p_rsp_after_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    capture_en |=> (rsp_valid && sram_oe_n));

  p_write_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_we_n) |-> (we_lo_cnt == WR_CLKS));

  p_drive_in_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_we_n |-> (sram_dq_oe && !sram_ce_n));

  p_hold_after_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_we_n) |-> sram_dq_oe);

  p_addr_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && $past(!req_ready)) |-> $stable(sram_addr));

  p_no_contention_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_we_n |-> sram_oe_n);

  p_single_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

endmodule

bind sram_timing_master sram_tm_checker #(
  .ADDR_W (ADDR_W),
  .RD_CLKS(RD_ACC_CLKS),
  .WR_CLKS(WR_ACC_CLKS)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .sram_addr (sram_addr),
  .sram_dq_oe(sram_dq_oe),
  .sram_ce_n (sram_ce_n),
  .sram_oe_n (sram_oe_n),
  .sram_we_n (sram_we_n),
  .capture_en(capture_en)
);

// File: tb/sram_timing_master_bench.sv
`timescale 1ns/1ps
module sram_timing_master_bench;

  localparam int PER = 4;
  localparam int WD_LIMIT = 100000;

  // Bench's own view of the interval counts
  function automatic int up_div(input int t, input int p);
    int q;
    q = t / p;
    if (t % p != 0) q = q + 1;
    return (q < 1) ? 1 : q;
  endfunction
  function automatic int bigger(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int E_RD_ACC  = 18;
  localparam int E_RD_REC  = 7;
  localparam int E_WR_ACC  = 18;
  localparam int E_WR_HOLD = 2;

  logic clk = 0;
  logic rst_n = 0;
  logic req_valid = 0, req_write = 0;
  logic [10:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic req_ready, rsp_valid, sram_dq_oe, sram_ce_n, sram_oe_n, sram_we_n;
  logic [7:0]  rsp_rdata, sram_dq_out, sram_dq_in;
  logic [10:0] sram_addr;

  always #(PER/2) clk = ~clk;

  sram_timing_master #(
    .CLK_PERIOD_NS(PER), .T_CYCLE_NS(70), .T_ACC_NS(70), .T_OE_ACC_NS(35),
    .T_WP_NS(50), .T_DS_NS(30), .T_DH_NS(5), .T_AH_NS(5), .T_HZ_NS(25)
  ) u_sram_timing_master (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .sram_addr(sram_addr),
    .sram_dq_out(sram_dq_out), .sram_dq_in(sram_dq_in), .sram_dq_oe(sram_dq_oe),
    .sram_ce_n(sram_ce_n), .sram_oe_n(sram_oe_n), .sram_we_n(sram_we_n)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Memory model: data only valid after the full access count
  logic [7:0] mem    [2048];
  logic [7:0] golden [2048];
  int lowcnt = 0;

  always @(posedge clk) lowcnt <= (!sram_ce_n && !sram_oe_n) ? lowcnt + 1 : 0;
  assign sram_dq_in = (!sram_ce_n && !sram_oe_n && lowcnt >= E_RD_ACC - 1)
                      ? mem[sram_addr] : 8'hEE;
  always @(posedge sram_we_n) if (rst_n) mem[sram_addr] = sram_dq_out;

  // Reference model, one step per clock
  int m_st = 0;   // 0 idle, 1 read access, 2 read recovery, 3 write, 4 write hold
  int m_cnt = 0;
  int m_addr = 0, m_data = 0;
  bit m_rv = 0;
  int m_rd = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_cnt = 0; m_rv = 0; m_addr = 0; m_data = 0;
    end else begin
      m_rv = 0;
      case (m_st)
        0: if (req_valid) begin
             m_addr = req_addr; m_data = req_wdata;
             if (req_write) begin m_st = 3; m_cnt = E_WR_ACC; golden[req_addr] = req_wdata; end
             else begin m_st = 1; m_cnt = E_RD_ACC; end
           end
        1: if (m_cnt == 1) begin m_st = 2; m_cnt = E_RD_REC; m_rv = 1; m_rd = golden[m_addr]; end
           else m_cnt--;
        2: if (m_cnt == 1) m_st = 0; else m_cnt--;
        3: if (m_cnt == 1) begin m_st = 4; m_cnt = E_WR_HOLD; end else m_cnt--;
        default: if (m_cnt == 1) m_st = 0; else m_cnt--;
      endcase
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      case (m_st)
        0: begin
          chk("R2 ready", req_ready, 1);
          chk("R2 ce_n", sram_ce_n, 1); chk("R2 we_n", sram_we_n, 1);
          chk("R2 oe_n", sram_oe_n, 1); chk("R2 dq_oe", sram_dq_oe, 0);
        end
        1: begin
          chk("R2 ready", req_ready, 0);
          chk("R3 ce_n", sram_ce_n, 0); chk("R3 oe_n", sram_oe_n, 0);
          chk("R3 we_n", sram_we_n, 1); chk("R3 dq_oe", sram_dq_oe, 0);
        end
        2: begin
          chk("R2 ready", req_ready, 0);
          chk("R5 ce_n", sram_ce_n, 1); chk("R5 oe_n", sram_oe_n, 1);
          chk("R5 we_n", sram_we_n, 1); chk("R5 dq_oe", sram_dq_oe, 0);
        end
        3: begin
          chk("R2 ready", req_ready, 0);
          chk("R6 ce_n", sram_ce_n, 0); chk("R6 we_n", sram_we_n, 0);
          chk("R9 oe_n", sram_oe_n, 1); chk("R6 dq_oe", sram_dq_oe, 1);
          chk("R6 dq_out", sram_dq_out, m_data);
        end
        default: begin
          chk("R2 ready", req_ready, 0);
          chk("R7 ce_n", sram_ce_n, 1); chk("R7 we_n", sram_we_n, 1);
          chk("R7 oe_n", sram_oe_n, 1); chk("R7 dq_oe", sram_dq_oe, 1);
          chk("R7 dq_out", sram_dq_out, m_data);
        end
      endcase
      if (m_st != 0) chk("R8 addr", sram_addr, m_addr);
      chk("R10 rsp_valid", rsp_valid, m_rv);
      if (m_rv) chk("R4 rdata", rsp_rdata, m_rd);
    end
  end

  // Issue one request; optionally scramble request fields while busy
  task automatic issue(input bit wr, input int addr, input int data, input bit noise);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = 11'(addr); req_wdata = 8'(data);
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    if (noise) begin
      for (int i = 0; i < 6; i++) begin
        req_write = ~req_write; req_addr = ~req_addr ^ 11'(i); req_wdata = req_wdata + 8'h11;
        @(negedge clk);
      end
    end
    req_valid = 0;
  endtask

  task automatic drain();
    while (!req_ready) @(negedge clk);
    @(negedge clk);
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc >= WD_LIMIT && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    for (int a = 0; a < 2048; a++) begin
      mem[a] = 8'(a) ^ 8'h3C;
      golden[a] = 8'(a) ^ 8'h3C;
    end
    // R11: conversion rule, independent bench arithmetic against the package
    chk("R11 zero", sram_tm_pkg::ns_to_clk(0, 4), up_div(0, PER));
    chk("R11 five", sram_tm_pkg::ns_to_clk(5, 4), 2);
    chk("R11 eight", sram_tm_pkg::ns_to_clk(8, 4), 2);
    chk("R11 rd_acc", E_RD_ACC, bigger(up_div(70, PER), up_div(35, PER)));
    chk("R11 rd_rec", E_RD_REC, bigger(up_div(25, PER), up_div(5, PER)));
    chk("R11 wr_acc", E_WR_ACC, bigger(up_div(50, PER), up_div(70, PER)));
    repeat (3) @(negedge clk);
    // R1 reset state, with a request pending that must be ignored
    req_valid = 1; req_write = 1;
    @(negedge clk);
    chk("R1 ready", req_ready, 1); chk("R1 ce_n", sram_ce_n, 1);
    chk("R1 oe_n", sram_oe_n, 1); chk("R1 we_n", sram_we_n, 1);
    chk("R1 dq_oe", sram_dq_oe, 0); chk("R1 rsp_valid", rsp_valid, 0);
    req_valid = 0; req_write = 0;
    @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);

    issue(1, 11'h000, 8'hA5, 0);   // lowest address
    issue(1, 11'h7FF, 8'h5A, 0);   // highest address
    issue(0, 11'h000, 0, 0);
    issue(0, 11'h7FF, 0, 0);
    issue(0, 11'h123, 0, 0);       // untouched location
    issue(1, 11'h456, 8'hC3, 1);   // noise while busy (R2)
    issue(0, 11'h456, 0, 1);       // write then read
    issue(1, 11'h456, 8'h3C, 0);   // read then write: turnaround (R5)
    issue(0, 11'h456, 0, 0);
    lfsr = 16'hACE1;
    for (int n = 0; n < 40; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      issue(lfsr[0], int'(lfsr[13:3]) & 32'h7, int'(lfsr[15:8]), lfsr[1]);
    end
    drain();
    repeat (4) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule